// File: doc/BRIEF.md
# UART Register Interface

This block connects a processor's memory bus to a byte-wide UART. It sits in a 4 KB memory-mapped window and answers a valid/ready bus. It has three word registers. A write to the transmit register passes the low byte of the write data to an external serializer. A read of the receive register returns the oldest byte held in an internal receive queue and removes it. A read of the status register shows whether the serializer is busy and whether received bytes are waiting.

The bit-level serial engines stay outside. The transmit side is a byte interface with valid/ready, plus a busy flag. The receive side offers one byte on each cycle that its valid is high. Most accesses complete in the cycle they are presented. Only a transmit write waits, holding the bus until the serializer takes the byte.

Top module: `uart_mmio_regs`

## Requirements
- R1: The block responds only to addresses from 0x1000_0000 to 0x1000_0FFF. For any other address, bus_ready stays low and nothing inside changes.
- R2: A write to offset 0x000 raises tx_valid in the same cycle, with tx_byte equal to bus_wdata[7:0]. The access completes in the cycle tx_ready is high.
- R3: While a write to offset 0x000 is presented and tx_ready is low, bus_ready stays low and the write stays pending.
- R4: A read of offset 0x004 with the queue non-empty returns the oldest byte in bits 7:0, with bits 31:8 at zero. On completion that byte is removed, so bytes come out in arrival order.
- R5: A read of offset 0x004 with the queue empty completes, returns zero and leaves the queue empty.
- R6: A read of offset 0x008 returns tx_busy in bit 0 and "queue not empty" in bit 1. Bits 31:2 read as zero.
- R7: The receive queue holds 16 bytes. A byte offered while it holds 16 is dropped, even in a cycle where a read removes an entry.
- R8: Any other offset in the window completes in one cycle and reads as zero. This includes misaligned offsets, a read of offset 0x000, and a write to offset 0x004 or 0x008. Writes to these offsets change nothing, and a write to 0x004 removes no byte.
- R9: After reset the receive queue is empty, so status bit 1 reads 0 and a read of offset 0x004 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus request present |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request completes this cycle |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high on a read |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_busy | input | 1 | Serializer is shifting out |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |

## Verification
Directed sequences cover specific cases:
- A few bytes pushed and then read back, which shows ordering.
- Twenty bytes pushed into the 16-entry queue, which separates the kept bytes from the dropped ones.
- A transmit write with tx_ready held low for several cycles, which tells a stall apart from a premature completion.
- Out-of-window, misaligned and read-only-write accesses, which separate "no effect" from a hidden pop or a spurious response.

A seeded random phase then mixes offsets, directions, serializer readiness and receive arrivals in every cycle. This reaches coincident push, pop and full conditions that the directed cases do not order by hand.

// File: rtl/uart_mmio_pkg.sv
// Package: shared register selector type and map offsets for the UART
// register interface. Assumes word registers at 12-bit window offsets.
package uart_mmio_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TX   = 2'd1,
        SEL_RX   = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    localparam logic [11:0] OFF_TX   = 12'h000;
    localparam logic [11:0] OFF_RX   = 12'h004;
    localparam logic [11:0] OFF_STAT = 12'h008;
endpackage

// File: rtl/uart_addr_decode.sv
// Module: uart_addr_decode
// Decodes a bus address into "in window" and a register selector.
// Assumes the window is aligned to its own size (2**WIN_BITS bytes).
module uart_addr_decode
    import uart_mmio_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 12,
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic [WIN_BITS-1:0] off;

    // Purpose: compare upper address bits against the window base.
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        off = addr[WIN_BITS-1:0];
    end

    // Purpose: map the in-window offset onto one of the registers.
    always_comb begin
        if (off == WIN_BITS'(OFF_TX))        sel = SEL_TX;
        else if (off == WIN_BITS'(OFF_RX))   sel = SEL_RX;
        else if (off == WIN_BITS'(OFF_STAT)) sel = SEL_STAT;
        else                                 sel = SEL_NONE;
    end

    logic unused_hi;
    assign unused_hi = (HI_W > 0);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Receive byte queue. A push while full is dropped, judged on the count
// before any same-cycle pop. A pop while empty is ignored.
// Assumes DEPTH >= 2.
module uart_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic              do_push, do_pop;

    // Purpose: qualify push and pop against the current fill level.
    always_comb begin
        do_push = push && (cnt != FULL_CNT);
        do_pop  = pop && (cnt != '0);
    end

    // Purpose: store an accepted byte.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wr_data;
    end

    // Purpose: advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign level   = cnt;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_CNT && push && !pop) |=> (cnt == FULL_CNT));
    a_r5_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && pop && !push) |=> (cnt == '0));
endmodule

// File: rtl/uart_read_mux.sv
// Module: uart_read_mux
// Builds the read data word from the selected register.
// Assumes rd_byte is only meaningful when the queue is not empty.
module uart_read_mux
    import uart_mmio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  reg_sel_e              sel,
    input  logic                  hit,
    input  logic                  q_empty,
    input  logic [BYTE_W-1:0]     rd_byte,
    input  logic                  tx_busy,
    output logic [DATA_W-1:0]     rdata
);
    // Purpose: return zero for TX and unmapped offsets, the queue head or
    // status otherwise.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                SEL_RX:   rdata[BYTE_W-1:0] = q_empty ? '0 : rd_byte;
                SEL_STAT: rdata[1:0] = {!q_empty, tx_busy};
                default:  rdata = '0;
            endcase
        end
    end

    always_comb begin
        if (hit && sel == SEL_STAT)
            a_r6_status_upper_zero: assert (rdata[DATA_W-1:2] == '0);
        if (hit && sel == SEL_RX)
            a_r4_rx_upper_zero: assert (rdata[DATA_W-1:BYTE_W] == '0);
    end
endmodule

// File: rtl/uart_mmio_regs.sv
// Module: uart_mmio_regs (top)
// Memory-mapped UART register interface: TX data write, RX data read with
// pop, status read. Single-cycle response except a TX write, which waits
// for tx_ready. Assumes one request at a time on the bus.
module uart_mmio_regs
    import uart_mmio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int          WIN_BITS  = 12,
    parameter int          RX_DEPTH  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_ready,
    input  logic        tx_busy,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte
);
    localparam int LVL_W = $clog2(RX_DEPTH + 1);

    logic           hit;
    reg_sel_e       sel;
    logic           tx_wr, rx_pop, q_empty;
    logic [7:0]     q_head;
    logic [LVL_W-1:0] q_level;

    uart_addr_decode #(
        .ADDR_W(32), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
    ) dec_i (
        .addr(bus_addr), .hit(hit), .sel(sel)
    );

    // Purpose: bus handshake and TX hand-off; only TX writes can stall.
    always_comb begin
        tx_wr     = bus_valid && hit && bus_we && (sel == SEL_TX);
        tx_valid  = tx_wr;
        tx_byte   = bus_wdata[7:0];
        bus_ready = bus_valid && hit && (!tx_wr || tx_ready);
        rx_pop    = bus_ready && !bus_we && (sel == SEL_RX);
    end

    uart_rx_fifo #(.DATA_W(8), .DEPTH(RX_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .wr_data(rx_byte),
        .pop(rx_pop), .rd_data(q_head),
        .empty(q_empty), .level(q_level)
    );

    uart_read_mux #(.DATA_W(32), .BYTE_W(8)) rmux_i (
        .sel(sel), .hit(hit), .q_empty(q_empty), .rd_byte(q_head),
        .tx_busy(tx_busy), .rdata(bus_rdata)
    );

    a_r1_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !hit) |-> !bus_ready);
    a_r2_tx_accept_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && tx_valid) |-> tx_ready);
    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> !bus_ready);
    a_r8_write_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !rx_valid) |=> (q_level == $past(q_level)));
endmodule

// File: tb/uart_mmio_regs_tb_top.sv
module uart_mmio_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1, tx_busy = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] q[$];

    uart_mmio_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .tx_busy(tx_busy), .rx_valid(rx_valid),
        .rx_byte(rx_byte)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [31:0] a);
        return a[31:12] == 20'h10000;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input bit busy);
        logic [11:0] off = a[11:0];
        if (off == 12'h004) return (q.size() > 0) ? {24'h0, q[0]} : 32'h0;
        if (off == 12'h008) return {30'h0, q.size() > 0, busy};
        return 32'h0;
    endfunction

    function automatic string req_of(input logic [31:0] a, input bit we);
        if (!in_win(a)) return "R1";
        if (a[11:0] == 12'h000 && we) return "R2";
        if (a[11:0] == 12'h004 && !we) return (q.size() > 0) ? "R4" : "R5";
        if (a[11:0] == 12'h008 && !we) return "R6";
        return "R8";
    endfunction

    // One bus cycle: drive at negedge, check before posedge, update model.
    task automatic cyc(input bit v, input bit we, input logic [31:0] a,
                       input logic [31:0] wd, input bit rv, input logic [7:0] rb,
                       input bit txr, input bit txb);
        bit e_ready, e_txv, pop;
        string rq;
        @(negedge clk);
        bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb; tx_ready = txr; tx_busy = txb;
        #2;
        rq = req_of(a, we);
        e_txv   = v && in_win(a) && we && a[11:0] == 12'h000;
        e_ready = v && in_win(a) && (!e_txv || txr);
        if (e_txv && !txr) rq = "R3";
        if (rv && q.size() == 16) rq = "R7";
        chk(bus_ready == e_ready, rq, "bus_ready", 32'(bus_ready), 32'(e_ready));
        chk(tx_valid == e_txv, rq, "tx_valid", 32'(tx_valid), 32'(e_txv));
        if (e_txv)
            chk(tx_byte == wd[7:0], "R2", "tx_byte", 32'(tx_byte), 32'(wd[7:0]));
        if (e_ready && !we)
            chk(bus_rdata == exp_read(a, txb), rq, "rdata", bus_rdata, exp_read(a, txb));
        pop = e_ready && !we && a[11:0] == 12'h004 && q.size() > 0;
        @(posedge clk);
        if (rv && q.size() < 16) q.push_back(rb);  // R7: judged before pop
        if (pop) void'(q.pop_front());
    endtask

    task automatic idle();
        cyc(0, 0, 32'h0, 32'h0, 0, 8'h0, 1, 0);
    endtask

    task automatic rd(input logic [31:0] a);
        cyc(1, 0, a, 32'h0, 0, 8'h0, 1, 0);
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "ALL", "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset with garbage arrivals: must not survive reset.
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk); rx_valid = 1'b0; rst_n = 1'b1;
        // R9: reset state
        rd(32'h1000_0008);
        rd(32'h1000_0004);
        // R4 ordering
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 8'hA0 + 8'(i), 1, 0);
        rd(32'h1000_0008);
        for (int i = 0; i < 3; i++) rd(32'h1000_0004);
        // R5 empty read
        rd(32'h1000_0004);
        rd(32'h1000_0008);
        // R7 overflow: 20 offered, 16 kept
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 8'(i + 1), 1, 0);
        // R7 full with pop in same cycle: arrival dropped
        cyc(1, 0, 32'h1000_0004, 0, 1, 8'h77, 1, 0);
        // R8 writes to RX/status and unmapped accesses change nothing
        cyc(1, 1, 32'h1000_0004, 32'hFF, 0, 0, 1, 0);
        cyc(1, 1, 32'h1000_0008, 32'hFF, 0, 0, 1, 0);
        cyc(1, 0, 32'h1000_0002, 0, 0, 0, 1, 0);
        cyc(1, 0, 32'h1000_0000, 0, 0, 0, 1, 0);
        cyc(1, 1, 32'h1000_0FFC, 32'h5A, 0, 0, 1, 0);
        // R1 outside window
        cyc(1, 0, 32'h1000_1004, 0, 0, 0, 1, 0);
        cyc(1, 0, 32'h0000_0004, 0, 0, 0, 1, 0);
        // R6 busy bit
        cyc(1, 0, 32'h1000_0008, 0, 0, 0, 1, 1);
        for (int i = 0; i < 17; i++) rd(32'h1000_0004);
        // R3 stall then R2 accept
        for (int i = 0; i < 4; i++) cyc(1, 1, 32'h1000_0000, 32'h1234_56C3, 0, 0, 0, 1);
        cyc(1, 1, 32'h1000_0000, 32'h1234_56C3, 0, 0, 1, 1);
        idle();
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            int k = $urandom_range(0, 9);
            case (k)
                0, 1, 2: a = 32'h1000_0004;
                3, 4:    a = 32'h1000_0000;
                5, 6:    a = 32'h1000_0008;
                7:       a = 32'h1000_0000 + {20'h0, 12'($urandom_range(0, 4095))};
                8:       a = 32'h1000_0001 + 32'($urandom_range(0, 2));
                default: a = 32'h2000_0000 + 32'($urandom_range(0, 15) * 4);
            endcase
            cyc($urandom_range(0, 9) < 8, $urandom_range(0, 2) == 0, a, $urandom(),
                $urandom_range(0, 9) < 5, 8'($urandom()),
                $urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1);
        end
        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule